// File: doc/BRIEF.md
# Block Transfer Address Generator

This block sequences a multi-register memory transfer. A single start request carries a 16-bit register mask, a base address, a two-bit addressing mode, a writeback enable, a load/store direction and a user-bank request. The block counts the set bits of the mask, derives the first word address from that count and the mode, then walks the mask from the lowest set bit to the highest. For each set bit it offers one word address and one register index to the external memory and register-file path through a valid/ready handshake.

When the last transfer has been accepted, the block raises a one-cycle completion pulse. With that pulse it presents the updated base value and a write strobe, which is active only when writeback was requested. For the whole operation it also holds three qualifiers. The first marks a load that writes the program counter, which is register 15. The second selects the user register bank. The third requests that the saved status be copied into the current status.

Top module: `blk_xfer_agen`

## Requirements
- R1: After an accepted start, exactly as many transfers complete (cycles with `xfer_valid` and `xfer_ready` both high) as there are set bits in `reg_mask`.
- R2: Mode 0 (ascend, address after) starts at `base_addr`. Mode 1 (ascend, address before) starts at `base_addr + 4`.
- R3: Mode 2 (descend, address after) starts at `base_addr - 4*N + 4`. Mode 3 (descend, address before) starts at `base_addr - 4*N`. N is the number of set bits.
- R4: Register indices are issued in ascending order, lowest set bit first. Each accepted transfer advances the address by 4. While `xfer_ready` is low, the address and index stay unchanged.
- R5: In the `done` cycle, `wb_data` is `base_addr + 4*N` for modes 0 and 1 and `base_addr - 4*N` for modes 2 and 3. `wb_we` is high in that cycle only if `wb_en` was set at start.
- R6: `pc_load` is high for the whole operation exactly when the operation is a load and mask bit 15 is set.
- R7: With `user_req` set, `user_bank` is high for a store, or for a load without bit 15. `status_restore` is high only for a load with bit 15. Without `user_req`, both are low.
- R8: An empty mask produces no transfers. `done` is high in the first cycle after the start edge.
- R9: A `start` pulse while `busy` is high is ignored and does not disturb the running operation.
- R10: After reset, `busy`, `xfer_valid`, `done` and `wb_we` are low.
- R11: `done` is a single-cycle pulse, and `xfer_valid` is low whenever `done` is high. `xfer_last` is high only on the final offered transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, taken only when idle |
| reg_mask | input | 16 | Register selection mask |
| base_addr | input | 32 | Base address |
| addr_mode | input | 2 | 0 ascend-after, 1 ascend-before, 2 descend-after, 3 descend-before |
| wb_en | input | 1 | Write back updated base |
| is_load | input | 1 | 1 load, 0 store |
| user_req | input | 1 | User-bank / status-restore request |
| busy | output | 1 | Operation in progress |
| xfer_valid | output | 1 | Transfer offered |
| xfer_ready | input | 1 | Transfer accepted |
| xfer_addr | output | 32 | Word address of the offered transfer |
| xfer_reg | output | 4 | Register index of the offered transfer |
| xfer_last | output | 1 | Offered transfer is the final one |
| done | output | 1 | Completion pulse |
| wb_we | output | 1 | Base writeback strobe |
| wb_data | output | 32 | Updated base value |
| pc_load | output | 1 | Load writes the program counter |
| user_bank | output | 1 | Use the user register bank |
| status_restore | output | 1 | Copy saved status into current status |

## Verification
The hardest case to reach from the ports is a `start` that arrives in the middle of a stalled transfer. That start carries a different mask, mode and base. The bench drives it while `xfer_ready` is being held low by a periodic stall pattern. A per-cycle reference queue then confirms that the remaining addresses, indices and writeback value still belong to the original request. Empty and full masks in each mode cover the count-dependent start and end addresses.

// File: rtl/blk_xfer_agen.sv
module blk_xfer_agen #(
  parameter int AW = 32,
  parameter int NREG = 16,
  parameter int WORD_BYTES = 4,
  localparam int IW = $clog2(NREG),
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NREG-1:0] reg_mask,
  input  logic [AW-1:0] base_addr,
  input  logic [1:0]    addr_mode,
  input  logic          wb_en,
  input  logic          is_load,
  input  logic          user_req,
  output logic          busy,
  output logic          xfer_valid,
  input  logic          xfer_ready,
  output logic [AW-1:0] xfer_addr,
  output logic [IW-1:0] xfer_reg,
  output logic          xfer_last,
  output logic          done,
  output logic          wb_we,
  output logic [AW-1:0] wb_data,
  output logic          pc_load,
  output logic          user_bank,
  output logic          status_restore
);

  logic [NREG-1:0] rem;
  logic [AW-1:0]   cur_addr, end_val;
  logic            wb_flag;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   span, first_addr, next_end;
  logic [IW-1:0]   low_idx;
  logic            top_bit;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CW'(reg_mask[i]);
  end

  assign span = AW'(cnt) * AW'(WORD_BYTES);

  always_comb begin
    unique case (addr_mode)
      2'd0: first_addr = base_addr;
      2'd1: first_addr = base_addr + AW'(WORD_BYTES);
      2'd2: first_addr = base_addr - span + AW'(WORD_BYTES);
      default: first_addr = base_addr - span;
    endcase
  end

  assign next_end = addr_mode[1] ? base_addr - span : base_addr + span;
  assign top_bit  = reg_mask[NREG-1];

  always_comb begin
    low_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (rem[i]) low_idx = IW'(i);
  end

  assign xfer_valid = busy && (rem != '0);
  assign done       = busy && (rem == '0);
  assign xfer_addr  = cur_addr;
  assign xfer_reg   = low_idx;
  assign xfer_last  = xfer_valid && ((rem & (rem - 1'b1)) == '0);
  assign wb_we      = done && wb_flag;
  assign wb_data    = end_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy           <= 1'b0;
      rem            <= '0;
      cur_addr       <= '0;
      end_val        <= '0;
      wb_flag        <= 1'b0;
      pc_load        <= 1'b0;
      user_bank      <= 1'b0;
      status_restore <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy           <= 1'b1;
        rem            <= reg_mask;
        cur_addr       <= first_addr;
        end_val        <= next_end;
        wb_flag        <= wb_en;
        pc_load        <= is_load && top_bit;
        user_bank      <= user_req && !(is_load && top_bit);
        status_restore <= user_req && is_load && top_bit;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else if (xfer_ready) begin
      rem            <= rem & ~(NREG'(1) << low_idx);
      cur_addr       <= cur_addr + AW'(WORD_BYTES);
    end
  end

endmodule

// File: rtl/blk_xfer_agen_chk.sv
module blk_xfer_agen_chk #(
  parameter int AW = 32,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          xfer_valid,
  input logic          xfer_ready,
  input logic [AW-1:0] xfer_addr,
  input logic [IW-1:0] xfer_reg,
  input logic          xfer_last,
  input logic          done,
  input logic          wb_we,
  input logic [AW-1:0] wb_data
);

  assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_reg));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && xfer_ready && !xfer_last |=> xfer_valid && (xfer_addr == $past(xfer_addr) + 32'd4));

  assert_reg_ascend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && xfer_ready && !xfer_last |=> xfer_reg > $past(xfer_reg));

  assert_last_then_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && xfer_ready && xfer_last |=> done);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_done_no_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !xfer_valid);

  assert_wb_in_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> done);

  assert_busy_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy && $stable(wb_data));

  assert_idle_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy);

endmodule

bind blk_xfer_agen blk_xfer_agen_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
  .xfer_reg(xfer_reg), .xfer_last(xfer_last), .done(done),
  .wb_we(wb_we), .wb_data(wb_data)
);

// File: tb/sim_blk_xfer_agen.sv
module sim_blk_xfer_agen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, wb_en = 1'b0, is_load = 1'b0, user_req = 1'b0, xfer_ready = 1'b0;
  logic [15:0] reg_mask = '0;
  logic [31:0] base_addr = '0;
  logic [1:0]  addr_mode = '0;
  logic busy, xfer_valid, xfer_last, done, wb_we, pc_load, user_bank, status_restore;
  logic [31:0] xfer_addr, wb_data;
  logic [3:0]  xfer_reg;

  int tests = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  blk_xfer_agen u0 (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [15:0] m, logic [31:0] b, logic [1:0] md, logic wb,
                        logic ld, logic s, bit stall, int poke_at);
    logic [31:0] aq[$];
    int rq[$];
    int n = 0, cyc = 0, xfers = 0;
    logic [31:0] a0, wbv;
    for (int i = 0; i < 16; i++) if (m[i]) n++;
    case (md)
      2'd0: a0 = b;
      2'd1: a0 = b + 4;
      2'd2: a0 = b - 32'(4 * n) + 4;
      default: a0 = b - 32'(4 * n);
    endcase
    wbv = md[1] ? b - 32'(4 * n) : b + 32'(4 * n);
    for (int i = 0, k = 0; i < 16; i++)
      if (m[i]) begin aq.push_back(a0 + 32'(4 * k)); rq.push_back(i); k++; end
    @(negedge clk);
    reg_mask = m; base_addr = b; addr_mode = md; wb_en = wb; is_load = ld; user_req = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      xfer_ready = stall ? (cyc % 3 != 1) : 1'b1;
      if (cyc == poke_at) begin
        start = 1'b1; reg_mask = 16'hFFFF; base_addr = 32'h0; addr_mode = 2'd3;
        wb_en = ~wb; is_load = ~ld; user_req = ~s;
      end else start = 1'b0;
      if (aq.size() > 0) begin
        chk("R1 valid", 32'(xfer_valid), 1);
        chk("R11 done low", 32'(done), 0);
        chk(md[1] ? "R3 R4 addr" : "R2 R4 addr", xfer_addr, aq[0]);
        chk("R4 reg", 32'(xfer_reg), 32'(rq[0]));
        chk("R11 last", 32'(xfer_last), 32'(aq.size() == 1));
        if (xfer_ready) begin void'(aq.pop_front()); void'(rq.pop_front()); xfers++; end
      end else begin
        chk("R8 R11 done", 32'(done), 1);
        chk("R11 valid low", 32'(xfer_valid), 0);
        chk("R1 count", 32'(xfers), 32'(n));
        chk("R5 wb_we", 32'(wb_we), 32'(wb));
        chk("R5 wb_data", wb_data, wbv);
        chk("R6 pc_load", 32'(pc_load), 32'(ld && m[15]));
        chk("R7 user_bank", 32'(user_bank), 32'(s && !(ld && m[15])));
        chk("R7 status_restore", 32'(status_restore), 32'(s && ld && m[15]));
        @(negedge clk);
        start = 1'b0;
        chk("R11 busy drop", 32'(busy), 0);
        chk("R11 done pulse", 32'(done), 0);
        if (cyc == 0) chk("R8 empty", 32'(n), 0);
        break;
      end
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #9;
    @(negedge clk);
    chk("R10 busy", 32'(busy), 0);
    chk("R10 valid", 32'(xfer_valid), 0);
    chk("R10 done", 32'(done), 0);
    chk("R10 wb_we", 32'(wb_we), 0);
    rst_n = 1'b1;
    run_op(16'h00F1, 32'h0000_1000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, -1);
    run_op(16'h8003, 32'h0000_2000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, -1);
    run_op(16'h0F0F, 32'h0000_3000, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, -1);
    run_op(16'h1248, 32'h0000_4000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 2);
    run_op(16'h0000, 32'h0000_5000, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, -1);
    run_op(16'h0000, 32'h0000_5000, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    run_op(16'hFFFF, 32'h0000_8000, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 5);
    run_op(16'h7FFE, 32'h0000_0100, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, -1);
    run_op(16'h8000, 32'hFFFF_FFF0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule